// File: doc/BRIEF.md
# PHY Control and Status Registers with Data-Path Isolation

This block holds the management control word of a 100 Mb/s PHY and turns its bits into side effects on the PHY's media-independent data interface. A management agent reads and writes it through a plain register port: one address strobe, one write strobe and 16-bit data. The serial management frame decoder sits upstream of this port. The block lies between the interface pins and the PHY core. It gates the transmit path into the core. It gates the receive path, the clocks and the collision signal out of the core. It produces an output-enable for every pin that can float.

The control word carries three live bits: power-down, isolate and collision-test. Power-down stops the data paths and holds the link state machine in reset with the oscillator disabled. While power-down is set, every control bit except power-down itself is frozen. Isolate floats the receive-side pins and ignores the transmit inputs, while management access keeps working. Collision-test sends the transmit-enable input out on the collision pin. A second address returns a status word whose capability bits all read zero.

Top module: `phy_ctl_regs`

## Requirements
- R1: After reset the control word at address 0 reads 0x0C00: power-down (bit 11) = 1, isolate (bit 10) = 1, collision-test (bit 7) = 0.
- R2: While power-down is 0, a write strobe to address 0 loads bits 11, 10 and 7 from the write data at the next clock edge. Read data is combinational from the addressed register.
- R3: While power-down is 1, a write to address 0 updates only bit 11. Bits 10 and 7 keep their values. This holds even when the same write clears bit 11.
- R4: While power-down is 1: link_rst_o = 1 and osc_en_o = 0. The core-side transmit outputs are 0. The interface receive data, receive valid, receive error, both clocks and collision are driven to 0.
- R5: While isolate is 1, the transmit data, enable and error inputs are ignored, and the core-side transmit outputs are 0.
- R6: While isolate is 1, all six output-enables are 0 and their data outputs are 0. Register reads and writes still work.
- R7: With collision-test = 1 and both power-down and isolate at 0, mii_col_o equals mii_tx_en_i and core_col_i is ignored. With collision-test = 0, mii_col_o equals core_col_i.
- R8: Control bits 15:12, 9, 8 and 6:0 always read 0, whatever is written.
- R9: Address 1 (status) reads 0x0000, and writes to it are ignored. Any other address reads 0x0000 and accepts no write.
- R10: With power-down and isolate both 0, transmit inputs pass to the core, receive signals and clocks pass to the pins, and all output-enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of addressed register |
| mii_txd_i | input | 4 | Transmit nibble from the interface |
| mii_tx_en_i | input | 1 | Transmit enable from the interface |
| mii_tx_er_i | input | 1 | Transmit error from the interface |
| core_txd_o | output | 4 | Gated transmit nibble to the core |
| core_tx_en_o | output | 1 | Gated transmit enable to the core |
| core_tx_er_o | output | 1 | Gated transmit error to the core |
| core_tx_clk_i | input | 1 | Transmit clock from the core |
| core_rx_clk_i | input | 1 | Receive clock from the core |
| core_rxd_i | input | 4 | Receive nibble from the core |
| core_rx_dv_i | input | 1 | Receive valid from the core |
| core_rx_er_i | input | 1 | Receive error from the core |
| core_col_i | input | 1 | Collision sense from the core |
| mii_tx_clk_o | output | 1 | Transmit clock pin value |
| mii_tx_clk_oe | output | 1 | Transmit clock pin enable |
| mii_rx_clk_o | output | 1 | Receive clock pin value |
| mii_rx_clk_oe | output | 1 | Receive clock pin enable |
| mii_rxd_o | output | 4 | Receive nibble pin value |
| mii_rxd_oe | output | 1 | Receive nibble pin enable |
| mii_rx_dv_o | output | 1 | Receive valid pin value |
| mii_rx_dv_oe | output | 1 | Receive valid pin enable |
| mii_rx_er_o | output | 1 | Receive error pin value |
| mii_rx_er_oe | output | 1 | Receive error pin enable |
| mii_col_o | output | 1 | Collision pin value |
| mii_col_oe | output | 1 | Collision pin enable |
| link_rst_o | output | 1 | Reset to the link state machine |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
Two things can happen in the same clock edge: a write that clears power-down, and the write lock that power-down imposes on the other bits. The bench provokes this with a single write of 0x0080 out of reset. That write tries to clear power-down, clear isolate and set collision-test at once. The read-back must be 0x0400, because the lock is judged on the power-down value held before the edge. A second overlap is collision-test running while the core's own collision input is asserted. There the bench drives the two inputs to opposite levels and checks that only transmit-enable reaches the collision pin.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int REG_W     = 16;
  localparam int BIT_PDOWN = 11;
  localparam int BIT_ISO   = 10;
  localparam int BIT_CTEST = 7;

  typedef struct packed {
    logic pdown;
    logic iso;
    logic ctest;
  } ctl_bits_t;

  localparam ctl_bits_t CTL_RESET = '{pdown: 1'b1, iso: 1'b1, ctest: 1'b0};

  function automatic logic [REG_W-1:0] pack_ctl(input ctl_bits_t c);
    logic [REG_W-1:0] w;
    w            = '0;
    w[BIT_PDOWN] = c.pdown;
    w[BIT_ISO]   = c.iso;
    w[BIT_CTEST] = c.ctest;
    return w;
  endfunction
endpackage

// File: rtl/phy_ctl_regfile.sv
module phy_ctl_regfile
  import phy_ctl_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int CTL_ADDR = 0,
  parameter int STS_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output ctl_bits_t         ctl
);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_ADDR);
  localparam logic [REG_W-1:0]  STS_FIXED = '0;

  ctl_bits_t ctl_q;
  ctl_bits_t ctl_nxt;
  logic      wr_hit;

  assign wr_hit = wr && (addr == CTL_A);

  // next state: power-down locks all other bits
  always_comb begin
    ctl_nxt       = ctl_q;
    ctl_nxt.pdown = wdata[BIT_PDOWN];
    if (!ctl_q.pdown) begin
      ctl_nxt.iso   = wdata[BIT_ISO];
      ctl_nxt.ctest = wdata[BIT_CTEST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
    end else if (wr_hit) begin
      ctl_q <= ctl_nxt;
    end
  end

  always_comb begin
    if (addr == CTL_A)      rdata = pack_ctl(ctl_q);
    else if (addr == STS_A) rdata = STS_FIXED;
    else                    rdata = '0;
  end

  assign ctl = ctl_q;

  // R3
  pdown_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == CTL_A && ctl_q.pdown) |=> ($stable(ctl_q.iso) && $stable(ctl_q.ctest)));

  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == CTL_A && !ctl_q.pdown) |=>
      (ctl_q.iso == $past(wdata[BIT_ISO]) && ctl_q.ctest == $past(wdata[BIT_CTEST])));

  // R9
  sts_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr != CTL_A) |=> $stable(ctl_q));
endmodule

// File: rtl/phy_ctl_mii_gate.sv
module phy_ctl_mii_gate
  import phy_ctl_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  ctl_bits_t         ctl,
  input  logic [DATA_W-1:0] txd_i,
  input  logic              tx_en_i,
  input  logic              tx_er_i,
  output logic [DATA_W-1:0] txd_o,
  output logic              tx_en_o,
  output logic              tx_er_o,
  input  logic              tx_clk_i,
  input  logic              rx_clk_i,
  input  logic [DATA_W-1:0] rxd_i,
  input  logic              rx_dv_i,
  input  logic              rx_er_i,
  input  logic              col_i,
  output logic              tx_clk_o,
  output logic              tx_clk_oe,
  output logic              rx_clk_o,
  output logic              rx_clk_oe,
  output logic [DATA_W-1:0] rxd_o,
  output logic              rxd_oe,
  output logic              rx_dv_o,
  output logic              rx_dv_oe,
  output logic              rx_er_o,
  output logic              rx_er_oe,
  output logic              col_o,
  output logic              col_oe
);
  localparam int N_PIN = 6;

  logic             run;
  logic             drv_on;
  logic             tx_pass;
  logic             col_src;
  logic [N_PIN-1:0] pin_raw;
  logic [N_PIN-1:0] pin_out;
  logic [N_PIN-1:0] pin_oe;

  assign run     = !ctl.pdown;
  assign drv_on  = !ctl.iso;
  assign tx_pass = run && drv_on;

  // transmit side toward the core
  assign txd_o   = tx_pass ? txd_i : '0;
  assign tx_en_o = tx_pass && tx_en_i;
  assign tx_er_o = tx_pass && tx_er_i;

  // collision source: loop-back of transmit enable in test mode
  assign col_src = ctl.ctest ? tx_en_i : col_i;

  // single-bit pins: tx_clk, rx_clk, rx_dv, rx_er, col, (slot 5 unused-free: rxd handled below)
  assign pin_raw = {1'b0, col_src, rx_er_i, rx_dv_i, rx_clk_i, tx_clk_i};

  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    assign pin_out[g] = run && drv_on && pin_raw[g];
    assign pin_oe[g]  = drv_on;
  end

  assign tx_clk_o  = pin_out[0];
  assign rx_clk_o  = pin_out[1];
  assign rx_dv_o   = pin_out[2];
  assign rx_er_o   = pin_out[3];
  assign col_o     = pin_out[4];
  assign tx_clk_oe = pin_oe[0];
  assign rx_clk_oe = pin_oe[1];
  assign rx_dv_oe  = pin_oe[2];
  assign rx_er_oe  = pin_oe[3];
  assign col_oe    = pin_oe[4];
  assign rxd_oe    = pin_oe[5];
  assign rxd_o     = (run && drv_on) ? rxd_i : '0;

  // R7
  always_comb begin
    if (ctl.ctest && run && drv_on) begin
      coltest_loop_chk: assert (col_o == tx_en_i);
    end
  end

  // R5
  always_comb begin
    if (ctl.iso) begin
      iso_tx_ignored_chk: assert (!tx_en_o && !tx_er_o && txd_o == '0);
    end
  end
endmodule

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
  import phy_ctl_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 4,
  parameter int CTL_ADDR = 0,
  parameter int STS_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [DATA_W-1:0] mii_txd_i,
  input  logic              mii_tx_en_i,
  input  logic              mii_tx_er_i,
  output logic [DATA_W-1:0] core_txd_o,
  output logic              core_tx_en_o,
  output logic              core_tx_er_o,
  input  logic              core_tx_clk_i,
  input  logic              core_rx_clk_i,
  input  logic [DATA_W-1:0] core_rxd_i,
  input  logic              core_rx_dv_i,
  input  logic              core_rx_er_i,
  input  logic              core_col_i,
  output logic              mii_tx_clk_o,
  output logic              mii_tx_clk_oe,
  output logic              mii_rx_clk_o,
  output logic              mii_rx_clk_oe,
  output logic [DATA_W-1:0] mii_rxd_o,
  output logic              mii_rxd_oe,
  output logic              mii_rx_dv_o,
  output logic              mii_rx_dv_oe,
  output logic              mii_rx_er_o,
  output logic              mii_rx_er_oe,
  output logic              mii_col_o,
  output logic              mii_col_oe,
  output logic              link_rst_o,
  output logic              osc_en_o
);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);

  ctl_bits_t ctl;

  phy_ctl_regfile #(
    .ADDR_W  (ADDR_W),
    .CTL_ADDR(CTL_ADDR),
    .STS_ADDR(STS_ADDR)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (reg_addr),
    .wr   (reg_wr),
    .wdata(reg_wdata),
    .rdata(reg_rdata),
    .ctl  (ctl)
  );

  phy_ctl_mii_gate #(
    .DATA_W(DATA_W)
  ) u_gate (
    .ctl      (ctl),
    .txd_i    (mii_txd_i),
    .tx_en_i  (mii_tx_en_i),
    .tx_er_i  (mii_tx_er_i),
    .txd_o    (core_txd_o),
    .tx_en_o  (core_tx_en_o),
    .tx_er_o  (core_tx_er_o),
    .tx_clk_i (core_tx_clk_i),
    .rx_clk_i (core_rx_clk_i),
    .rxd_i    (core_rxd_i),
    .rx_dv_i  (core_rx_dv_i),
    .rx_er_i  (core_rx_er_i),
    .col_i    (core_col_i),
    .tx_clk_o (mii_tx_clk_o),
    .tx_clk_oe(mii_tx_clk_oe),
    .rx_clk_o (mii_rx_clk_o),
    .rx_clk_oe(mii_rx_clk_oe),
    .rxd_o    (mii_rxd_o),
    .rxd_oe   (mii_rxd_oe),
    .rx_dv_o  (mii_rx_dv_o),
    .rx_dv_oe (mii_rx_dv_oe),
    .rx_er_o  (mii_rx_er_o),
    .rx_er_oe (mii_rx_er_oe),
    .col_o    (mii_col_o),
    .col_oe   (mii_col_oe)
  );

  // link state machine held and oscillator stopped while powered down
  assign link_rst_o = ctl.pdown;
  assign osc_en_o   = !ctl.pdown;

  // R4
  pdown_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTL_A && reg_rdata[BIT_PDOWN]) |->
      (link_rst_o && !osc_en_o && !core_tx_en_o && !mii_rx_dv_o && !mii_col_o));

  // R6
  iso_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTL_A && reg_rdata[BIT_ISO]) |->
      (!mii_rxd_oe && !mii_col_oe && !mii_tx_clk_oe && !mii_rx_clk_oe && !mii_rx_dv_oe && !mii_rx_er_oe));

  // R8
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTL_A) |-> ($countones(reg_rdata) == $countones({reg_rdata[BIT_PDOWN], reg_rdata[BIT_ISO], reg_rdata[BIT_CTEST]})));
endmodule

// File: tb/phy_ctl_regs_tb.sv
module phy_ctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  reg_addr;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [3:0]  mii_txd_i;
  logic        mii_tx_en_i, mii_tx_er_i;
  logic [3:0]  core_txd_o;
  logic        core_tx_en_o, core_tx_er_o;
  logic        core_tx_clk_i, core_rx_clk_i;
  logic [3:0]  core_rxd_i;
  logic        core_rx_dv_i, core_rx_er_i, core_col_i;
  logic        mii_tx_clk_o, mii_tx_clk_oe, mii_rx_clk_o, mii_rx_clk_oe;
  logic [3:0]  mii_rxd_o;
  logic        mii_rxd_oe, mii_rx_dv_o, mii_rx_dv_oe, mii_rx_er_o, mii_rx_er_oe;
  logic        mii_col_o, mii_col_oe, link_rst_o, osc_en_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  phy_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mii_txd_i(mii_txd_i), .mii_tx_en_i(mii_tx_en_i), .mii_tx_er_i(mii_tx_er_i),
    .core_txd_o(core_txd_o), .core_tx_en_o(core_tx_en_o), .core_tx_er_o(core_tx_er_o),
    .core_tx_clk_i(core_tx_clk_i), .core_rx_clk_i(core_rx_clk_i),
    .core_rxd_i(core_rxd_i), .core_rx_dv_i(core_rx_dv_i), .core_rx_er_i(core_rx_er_i),
    .core_col_i(core_col_i),
    .mii_tx_clk_o(mii_tx_clk_o), .mii_tx_clk_oe(mii_tx_clk_oe),
    .mii_rx_clk_o(mii_rx_clk_o), .mii_rx_clk_oe(mii_rx_clk_oe),
    .mii_rxd_o(mii_rxd_o), .mii_rxd_oe(mii_rxd_oe),
    .mii_rx_dv_o(mii_rx_dv_o), .mii_rx_dv_oe(mii_rx_dv_oe),
    .mii_rx_er_o(mii_rx_er_o), .mii_rx_er_oe(mii_rx_er_oe),
    .mii_col_o(mii_col_o), .mii_col_oe(mii_col_oe),
    .link_rst_o(link_rst_o), .osc_en_o(osc_en_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [5:0] oes();
    return {mii_tx_clk_oe, mii_rx_clk_oe, mii_rxd_oe, mii_rx_dv_oe, mii_rx_er_oe, mii_col_oe};
  endfunction

  task automatic drive_traffic();
    mii_txd_i = 4'hA; mii_tx_en_i = 1'b1; mii_tx_er_i = 1'b1;
    core_rxd_i = 4'h5; core_rx_dv_i = 1'b1; core_rx_er_i = 1'b1;
    core_col_i = 1'b1; core_tx_clk_i = 1'b1; core_rx_clk_i = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd_reg(5'd0, d);
    chk("R1", "ctl after reset", 32'(d), 32'h0C00);
    chk("R4", "link_rst/osc_en", {link_rst_o, osc_en_o}, 2'b10);
    chk("R6", "oe after reset", 32'(oes()), 32'h0);
    rd_reg(5'd1, d);
    chk("R9", "status read", 32'(d), 32'h0);
  endtask

  task automatic t_pdown_lock_same_cycle();
    logic [15:0] d;
    wr_reg(5'd0, 16'h0080);
    rd_reg(5'd0, d);
    chk("R3", "clear pdown with ctest/iso change", 32'(d), 32'h0400);
    chk("R4", "osc_en after pdown clear", 32'(osc_en_o), 32'h1);
  endtask

  task automatic t_isolate();
    logic [15:0] d;
    drive_traffic();
    chk("R5", "core tx gated", {core_txd_o, core_tx_en_o, core_tx_er_o}, 6'h0);
    chk("R6", "oe isolated", 32'(oes()), 32'h0);
    chk("R6", "pin data isolated", {mii_rxd_o, mii_rx_dv_o, mii_col_o, mii_tx_clk_o}, 7'h0);
    wr_reg(5'd0, 16'h0480);
    rd_reg(5'd0, d);
    chk("R6", "write while isolated", 32'(d), 32'h0480);
  endtask

  task automatic t_normal();
    logic [15:0] d;
    wr_reg(5'd0, 16'h0000);
    drive_traffic();
    rd_reg(5'd0, d);
    chk("R2", "ctl normal", 32'(d), 32'h0000);
    chk("R10", "core tx pass", {core_txd_o, core_tx_en_o, core_tx_er_o}, {4'hA, 2'b11});
    chk("R10", "rx pins pass", {mii_rxd_o, mii_rx_dv_o, mii_rx_er_o, mii_tx_clk_o, mii_rx_clk_o}, {4'h5, 4'hF});
    chk("R10", "oe all on", 32'(oes()), 32'h3F);
    core_col_i = 1'b1; mii_tx_en_i = 1'b0; #1;
    chk("R7", "col follows core when test off", 32'(mii_col_o), 32'h1);
  endtask

  task automatic t_coltest();
    wr_reg(5'd0, 16'h0080);
    mii_tx_en_i = 1'b1; core_col_i = 1'b0; #1;
    chk("R7", "col from tx_en high", 32'(mii_col_o), 32'h1);
    mii_tx_en_i = 1'b0; core_col_i = 1'b1; #1;
    chk("R7", "col from tx_en low, core col ignored", 32'(mii_col_o), 32'h0);
  endtask

  task automatic t_reserved();
    logic [15:0] d;
    wr_reg(5'd0, 16'hF37F);
    rd_reg(5'd0, d);
    chk("R8", "reserved bits read 0", 32'(d), 32'h0000);
    wr_reg(5'd1, 16'hFFFF);
    rd_reg(5'd1, d);
    chk("R9", "status write ignored", 32'(d), 32'h0);
    rd_reg(5'd0, d);
    chk("R9", "ctl untouched by status write", 32'(d), 32'h0000);
    wr_reg(5'd2, 16'hFFFF);
    rd_reg(5'd2, d);
    chk("R9", "unmapped address", 32'(d), 32'h0);
    rd_reg(5'd0, d);
    chk("R9", "ctl untouched by unmapped write", 32'(d), 32'h0000);
  endtask

  task automatic t_pdown();
    logic [15:0] d;
    wr_reg(5'd0, 16'h0800);
    drive_traffic();
    chk("R4", "link_rst/osc_en", {link_rst_o, osc_en_o}, 2'b10);
    chk("R4", "core tx stopped", {core_txd_o, core_tx_en_o, core_tx_er_o}, 6'h0);
    chk("R4", "rx pins stopped", {mii_rxd_o, mii_rx_dv_o, mii_rx_er_o, mii_tx_clk_o, mii_rx_clk_o, mii_col_o}, 10'h0);
    wr_reg(5'd0, 16'h0C80);
    rd_reg(5'd0, d);
    chk("R3", "other bits locked", 32'(d), 32'h0800);
    wr_reg(5'd0, 16'h0000);
    rd_reg(5'd0, d);
    chk("R2", "pdown cleared", 32'(d), 32'h0000);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    mii_txd_i = '0; mii_tx_en_i = 1'b0; mii_tx_er_i = 1'b0;
    core_rxd_i = '0; core_rx_dv_i = 1'b0; core_rx_er_i = 1'b0;
    core_col_i = 1'b0; core_tx_clk_i = 1'b0; core_rx_clk_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pdown_lock_same_cycle();
    t_isolate();
    t_normal();
    t_coltest();
    t_reserved();
    t_pdown();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule